// File: doc/BRIEF.md
# General-Purpose I/O Bank with Atomic Set and Clear

This block controls one bank of general-purpose pins, 32 by default, through a small word-addressed register bus. Software picks, per pin, whether the pin listens or drives. It loads the output latch either as a whole word or through two write-only ports. One of these ports raises bits and the other lowers them. In each case only the bits written as 1 are affected. Because of this, two agents can change separate pins without a read-modify-write sequence.

Every pad level comes back through a two-stage synchronizer into a read-only input word. The input word shows the pad for every pin, whatever its direction. A level that the bank drives itself therefore reads back two clock edges after the pad moves. Register accesses complete in one clock. A write takes effect at the edge where the write strobe is sampled. A read returns data combinationally from the current word offset.

Top module: `gpio_bank`

## Requirements
- R1: During and after a synchronous active-low reset, the direction word reads all ones, the output latch reads zero, and pad_oe and pad_out are all zero.
- R2: Word offset 0 holds the direction word. A 1 bit makes that pin an input (pad_oe bit 0). A 0 bit makes it drive (pad_oe bit 1). A write updates pad_oe at the sampling edge, and a read returns the stored word.
- R3: Word offset 1 holds the output latch. A write replaces the whole latch. pad_out always equals the latch, including for pins set as inputs.
- R4: A write to word offset 2 sets every latch bit whose write-data bit is 1 and leaves the bits written as 0 unchanged.
- R5: A write to word offset 3 clears every latch bit whose write-data bit is 1 and leaves the bits written as 0 unchanged.
- R6: A read of offset 2 or of offset 3 returns the current output latch.
- R7: Word offset 4 returns the synchronized pad level of every pin, including pins that are driving. Writes to offset 4 change neither the latch nor the direction word.
- R8: A pad change sampled at clock edge k reads back at offset 4 after edge k+1 and not before it.
- R9: Offsets 5 to 7 read as zero. Writes to them change neither the latch nor the direction word.
- R10: With no write strobe, pad_out and pad_oe hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Write strobe, sampled at the rising edge |
| reg_addr | input | 3 | Word offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| pad_in | input | 32 | Raw pad levels, asynchronous |
| pad_out | output | 32 | Level driven onto each pad |
| pad_oe | output | 32 | Per-pin drive enable, 1 = drive |

## Verification
Two things can happen in the same cycle: the output latch changes through a set, clear or whole-word write, and the synchronizer samples a pad that is looped back from pad_out. The bench feeds pad_out straight back into pad_in for stretches of the random run. It then reads the input word one edge and two edges after each latch write. The expected value is the latch content from two edges earlier, not the content just written. Separately, pad_in is moved on its own in the same cycle as a latch write. This confirms that the synchronizer path and the write path do not disturb each other.

// File: rtl/gpio_bank_pkg.sv
// Package: shared register offsets and strobe bundle for the GPIO bank.
// Assumes the bus carries word offsets, not byte addresses.
package gpio_bank_pkg;

    // Word offsets of the bank registers; the order is fixed by software.
    typedef enum logic [2:0] {
        OFF_DIR = 3'd0,
        OFF_OUT = 3'd1,
        OFF_SET = 3'd2,
        OFF_CLR = 3'd3,
        OFF_IN  = 3'd4
    } reg_off_e;

    // One-hot write strobes produced by the decoder.
    typedef struct packed {
        logic dir;
        logic out;
        logic set;
        logic clr;
    } wr_strb_t;

endpackage

// File: rtl/gpio_bank_sync.sv
// Module: multi-stage synchronizer for a vector of asynchronous pad inputs.
// Assumes each bit is independent (no bus coherence required) and STAGES >= 1.
module gpio_bank_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // Capture the raw pads into the first stage.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= din;
            end
        end else begin : g_next
            // Shift the previous stage forward.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_bank_wdec.sv
// Module: write decoder turning a word offset and strobe into one-hot enables.
// Assumes unused offsets must produce no strobe at all.
module gpio_bank_wdec
    import gpio_bank_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output wr_strb_t          strb
);

    localparam logic [ADDR_W-1:0] A_DIR = ADDR_W'(OFF_DIR);
    localparam logic [ADDR_W-1:0] A_OUT = ADDR_W'(OFF_OUT);
    localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(OFF_SET);
    localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(OFF_CLR);

    // Decode the offset into at most one active strobe.
    always_comb begin
        strb     = '0;
        strb.dir = wr && (addr == A_DIR);
        strb.out = wr && (addr == A_OUT);
        strb.set = wr && (addr == A_SET);
        strb.clr = wr && (addr == A_CLR);
    end

endmodule

// File: rtl/gpio_bank_latch.sv
// Module: direction word and output latch with whole-word, set and clear updates.
// Assumes at most one strobe is active per cycle.
module gpio_bank_latch
    import gpio_bank_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  wr_strb_t     strb,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] out_q
);

    logic [W-1:0] out_d;

    // Direction word: resets to all inputs, replaced on a direction write.
    always_ff @(posedge clk) begin
        if (!rst_n)        dir_q <= '1;
        else if (strb.dir) dir_q <= wdata;
    end

    // Next latch value for the three update styles.
    always_comb begin
        out_d = out_q;
        if (strb.out)      out_d = wdata;
        else if (strb.set) out_d = out_q | wdata;
        else if (strb.clr) out_d = out_q & ~wdata;
    end

    // Output latch register.
    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

endmodule

// File: rtl/gpio_bank_rmux.sv
// Module: combinational read multiplexer over the bank's words.
// Assumes unmapped offsets return zero.
module gpio_bank_rmux
    import gpio_bank_pkg::*;
#(
    parameter int W      = 32,
    parameter int ADDR_W = 3
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      dir_q,
    input  logic [W-1:0]      out_q,
    input  logic [W-1:0]      pad_sync,
    output logic [W-1:0]      rdata
);

    localparam logic [ADDR_W-1:0] A_DIR = ADDR_W'(OFF_DIR);
    localparam logic [ADDR_W-1:0] A_OUT = ADDR_W'(OFF_OUT);
    localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(OFF_SET);
    localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(OFF_CLR);
    localparam logic [ADDR_W-1:0] A_IN  = ADDR_W'(OFF_IN);

    // Select the word addressed by the current offset.
    always_comb begin
        if (addr == A_DIR)
            rdata = dir_q;
        else if (addr == A_OUT || addr == A_SET || addr == A_CLR)
            rdata = out_q;
        else if (addr == A_IN)
            rdata = pad_sync;
        else
            rdata = '0;
    end

endmodule

// File: rtl/gpio_bank.sv
// Module: top of one GPIO bank: register bus, direction, output latch, input sync.
// Assumes the bus issues one access per cycle and pads are asynchronous to clk.
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int NPINS       = 32,
    parameter int ADDR_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [NPINS-1:0]  reg_wdata,
    output logic [NPINS-1:0]  reg_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe
);

    wr_strb_t         strb;
    logic [NPINS-1:0] dir_q;
    logic [NPINS-1:0] out_q;
    logic [NPINS-1:0] pad_sync;

    gpio_bank_wdec #(.ADDR_W(ADDR_W)) u_wdec (
        .wr   (reg_wr),
        .addr (reg_addr),
        .strb (strb)
    );

    gpio_bank_latch #(.W(NPINS)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .strb  (strb),
        .wdata (reg_wdata),
        .dir_q (dir_q),
        .out_q (out_q)
    );

    gpio_bank_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pad_in),
        .dout  (pad_sync)
    );

    gpio_bank_rmux #(.W(NPINS), .ADDR_W(ADDR_W)) u_rmux (
        .addr     (reg_addr),
        .dir_q    (dir_q),
        .out_q    (out_q),
        .pad_sync (pad_sync),
        .rdata    (reg_rdata)
    );

    // Pad drive: a direction bit of 1 means input, so the enable is its inverse.
    assign pad_oe  = ~dir_q;
    assign pad_out = out_q;

endmodule

// File: rtl/gpio_bank_chk.sv
// Module: protocol checker for gpio_bank, attached by bind below.
// Assumes it sees only the top-level ports.
module gpio_bank_chk #(
    parameter int NPINS       = 32,
    parameter int ADDR_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [NPINS-1:0]  reg_wdata,
    input logic [NPINS-1:0]  reg_rdata,
    input logic [NPINS-1:0]  pad_in,
    input logic [NPINS-1:0]  pad_out,
    input logic [NPINS-1:0]  pad_oe
);

    localparam logic [ADDR_W-1:0] A_DIR = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_OUT = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(3);
    localparam logic [ADDR_W-1:0] A_IN  = ADDR_W'(4);

    logic       seen_edge;
    logic [1:0] run_cnt;

    // Mark that at least one edge has passed, so $past is meaningful.
    always_ff @(posedge clk) seen_edge <= 1'b1;

    // Count cycles out of reset, saturating at 3.
    always_ff @(posedge clk) begin
        if (!rst_n)             run_cnt <= '0;
        else if (run_cnt != 3)  run_cnt <= run_cnt + 2'd1;
    end

    p_reset_state_r1: assert property (@(posedge clk)
        (seen_edge === 1'b1 && !$past(rst_n)) |-> (pad_oe == '0 && pad_out == '0));

    p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_DIR) |=> (pad_oe == ~$past(reg_wdata)));

    p_whole_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_OUT) |=> (pad_out == $past(reg_wdata)));

    p_set_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_SET) |=> (pad_out == ($past(pad_out) | $past(reg_wdata))));

    p_clear_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_CLR) |=> (pad_out == ($past(pad_out) & ~$past(reg_wdata))));

    p_alias_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == A_SET || reg_addr == A_CLR) |-> (reg_rdata == pad_out));

    p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> ($stable(pad_out) && $stable(pad_oe)));

    p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr > A_IN) |-> (reg_rdata == '0));

    if (SYNC_STAGES == 2) begin : g_lat
        p_sync_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (run_cnt == 2'd3 && reg_addr == A_IN) |-> (reg_rdata == $past(pad_in, 2)));
    end

endmodule

bind gpio_bank gpio_bank_chk #(
    .NPINS(NPINS), .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe)
);

// File: tb/gpio_bank_test.sv
// Bench: seeded random register traffic mixed with directed corner cases.
module gpio_bank_test;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_wr = 1'b0;
    logic [2:0]   reg_addr = 3'd0;
    logic [W-1:0] reg_wdata = '0;
    logic [W-1:0] reg_rdata;
    logic [W-1:0] pad_in = '0;
    logic [W-1:0] pad_out;
    logic [W-1:0] pad_oe;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    bit loopback = 1'b0;

    logic [W-1:0] dir_m = '1;
    logic [W-1:0] out_m = '0;
    logic [W-1:0] s1_m  = '0;
    logic [W-1:0] s2_m  = '0;

    gpio_bank uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    always #5 clk = ~clk;

    function automatic logic [W-1:0] next_out(input logic [2:0] a, input logic [W-1:0] cur,
                                              input logic [W-1:0] d);
        case (a)
            3'd1:    return d;
            3'd2:    return cur | d;
            3'd3:    return cur & ~d;
            default: return cur;
        endcase
    endfunction

    function automatic logic [W-1:0] exp_read(input logic [2:0] a);
        case (a)
            3'd0:           return dir_m;
            3'd1, 3'd2, 3'd3: return out_m;
            3'd4:           return s2_m;
            default:        return '0;
        endcase
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock: model the synchronizer at the edge, then settle 1 ns after.
    task automatic tick();
        @(posedge clk);
        s2_m = s1_m;
        s1_m = pad_in;
        #1;
        if (loopback) pad_in = pad_out;
    endtask

    task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
        if (rst_n) begin
            if (a == 3'd0) dir_m = d;
            out_m = next_out(a, out_m, d);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic check_pads(input string req);
        check({req, " pad_out"}, pad_out, out_m);
        check({req, " pad_oe"},  pad_oe, ~dir_m);
    endtask

    initial begin
        logic [W-1:0] v;
        void'($urandom(32'h6b1a_2c07));
        // R1: reset state.
        repeat (3) tick();
        check_pads("R1");
        rd(3'd0, v); check("R1 dir", v, '1);
        rd(3'd1, v); check("R1 out", v, '0);
        rst_n = 1'b1;
        tick();
        check_pads("R1 after release");

        // R2: direction write drives the enables.
        wr(3'd0, 32'h0000_FFFF); check_pads("R2");
        rd(3'd0, v); check("R2 read", v, 32'h0000_FFFF);
        // R3: whole-word write, latch drives even input pins.
        wr(3'd1, 32'hA5A5_5A5A); check_pads("R3");
        // R4 / R5: set and clear leave zero bits alone.
        wr(3'd2, 32'h0F00_0001); check_pads("R4");
        check("R4 value", pad_out, 32'hAFA5_5A5B);
        wr(3'd3, 32'h8000_0003); check_pads("R5");
        check("R5 value", pad_out, 32'h2FA5_5A58);
        wr(3'd2, 32'h0); check("R4 zero word", pad_out, 32'h2FA5_5A58);
        wr(3'd3, 32'h0); check("R5 zero word", pad_out, 32'h2FA5_5A58);
        // R6: set and clear offsets read the latch.
        rd(3'd2, v); check("R6 set read", v, out_m);
        rd(3'd3, v); check("R6 clr read", v, out_m);

        // R8: latency of a pad change.
        pad_in = 32'h1234_5678;
        tick(); rd(3'd4, v); check("R8 one edge old", v, 32'h0);
        tick(); rd(3'd4, v); check("R8 two edges new", v, 32'h1234_5678);
        // R7: writes to the input offset change nothing; input shows driven pins too.
        wr(3'd4, 32'hFFFF_FFFF); check_pads("R7 write ignored");
        rd(3'd4, v); check("R7 input", v, 32'h1234_5678);
        // R9: unmapped offsets.
        for (int a = 5; a < 8; a++) begin
            wr(3'(a), 32'hDEAD_BEEF); check_pads("R9 write ignored");
            rd(3'(a), v); check("R9 read zero", v, '0);
        end
        // R10: idle cycles hold the pads.
        repeat (4) tick();
        check_pads("R10");

        // Random traffic, with loopback stretches where a latch write and the
        // pad sample of the previous latch value fall in the same cycle.
        for (int i = 0; i < 600; i++) begin
            int op;
            if (i % 100 == 0) loopback = ~loopback;
            op = int'($urandom % 8);
            if (op < 5) begin
                logic [2:0] a;
                a = 3'($urandom % 8);
                if (!loopback && ($urandom % 2) == 1) pad_in = $urandom;
                wr(a, $urandom);
                check_pads("R3 R4 R5 random");
            end else if (op < 7) begin
                logic [2:0] a;
                a = 3'($urandom % 8);
                rd(a, v);
                check("R6 R7 R9 random read", v, exp_read(a));
                tick();
            end else begin
                if (!loopback) pad_in = $urandom;
                tick();
                rd(3'd4, v); check("R8 random input", v, s2_m);
            end
        end

        // R1 again: reset mid-run restores the defaults.
        loopback = 1'b0;
        rst_n = 1'b0;
        tick();
        dir_m = '1; out_m = '0;
        check_pads("R1 mid-run");
        rst_n = 1'b1;

        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule